// File: doc/BRIEF.md
# Periodic Tick and Watchdog Interrupt Generator

This block turns a 32.768 kHz slow-clock enable into a 64 Hz heartbeat. It counts 512 slow pulses per tick and raises a level tick interrupt on each tick. If software has not acknowledged a tick by the time the next one arrives, a second level line, the watchdog-expired interrupt, is raised as well. A single register-bus write to the acknowledge address drops both lines.

The whole block runs on the system clock. The slow clock arrives as a one-cycle enable pulse that is already synchronised to the system clock. A test input makes every slow pulse a tick, so that a simulation or production test does not have to wait 512 pulses.

Top module: `tick_wdog_irq`

## Requirements
- R1: After reset both interrupt lines are low and the divider is at zero. The first tick falls on exactly the 512th slow pulse after reset.
- R2: With test bypass low, a tick occurs on every 512th slow pulse. System-clock cycles without a slow pulse change nothing.
- R3: A tick drives `tick_irq` high on the next clock. A write to the acknowledge address `EOI_ADDR` (default 0x0C) drives it low on the next clock.
- R4: A tick that arrives while `tick_irq` is already high also drives `wdog_irq` high on the next clock.
- R5: `wdog_irq` stays high through further ticks until an acknowledge write, which clears it together with `tick_irq`.
- R6: The write data is ignored: any value written to `EOI_ADDR` clears both lines. A write to any other address changes neither line.
- R7: If a tick and an acknowledge write fall in the same cycle, `tick_irq` ends high. `wdog_irq` is set if `tick_irq` was high before that cycle, and otherwise it is cleared.
- R8: While `test_bypass` is high, every slow pulse is a tick and returns the divider to zero. The next normal tick comes 512 pulses after the last pulse in bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_ce | input | 1 | One-cycle enable per 32.768 kHz period |
| test_bypass | input | 1 | Treat every slow pulse as a tick |
| bus_wr | input | 1 | Register-bus write strobe |
| bus_addr | input | AW (8) | Register-bus word address |
| bus_wdata | input | DW (32) | Write data, ignored |
| tick_irq | output | 1 | Tick interrupt, level |
| wdog_irq | output | 1 | Watchdog-expired interrupt, level |

## Verification
The bound checker watches the interrupt state machine on every cycle. It checks that a tick sets the tick line, that an acknowledge without a tick clears both lines, that a tick on a pending interrupt sets the watchdog line, that the watchdog line holds when no acknowledge arrives, and that the divider does not move between slow pulses. What only the bench can show is the exact 512-pulse spacing from reset and between ticks, the bypass behaviour and the divider restart after it, and that the write data and other addresses have no effect on either line.

// File: rtl/tick_wdog_irq.sv
module tick_wdog_irq #(
  parameter int DIV      = 512,
  parameter int AW       = 8,
  parameter int DW       = 32,
  parameter int EOI_ADDR = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slow_ce,
  input  logic          test_bypass,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic          tick_irq,
  output logic          wdog_irq
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;
  logic          tick_ev;
  logic          eoi;
  logic          unused_wdata;

  assign unused_wdata = ^bus_wdata;
  assign tick_ev = slow_ce && (test_bypass || cnt == LAST);
  assign eoi     = bus_wr && (bus_addr == AW'(EOI_ADDR));

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (slow_ce)
      cnt <= (test_bypass || cnt == LAST) ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_irq <= 1'b0;
      wdog_irq <= 1'b0;
    end else begin
      if (tick_ev)       tick_irq <= 1'b1;
      else if (eoi)      tick_irq <= 1'b0;
      if (tick_ev && tick_irq) wdog_irq <= 1'b1;
      else if (eoi)            wdog_irq <= 1'b0;
    end
  end
endmodule

// File: rtl/tick_wdog_irq_chk.sv
module tick_wdog_irq_chk #(
  parameter int AW       = 8,
  parameter int CW       = 9,
  parameter int EOI_ADDR = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          slow_ce,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic          tick_ev,
  input logic [CW-1:0] cnt,
  input logic          tick_irq,
  input logic          wdog_irq
);
  logic ack;
  assign ack = bus_wr && (bus_addr == AW'(EOI_ADDR));

  // R3
  tick_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_ev |=> tick_irq);

  // R3
  ack_clears_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !tick_ev) |=> !tick_irq);

  // R4
  wdog_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_ev && tick_irq) |=> wdog_irq);

  // R5
  wdog_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wdog_irq && !ack) |=> wdog_irq);

  // R5
  ack_clears_wdog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !(tick_ev && tick_irq)) |=> !wdog_irq);

  // R2
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slow_ce |=> $stable(cnt));

  // R2
  tick_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_irq && !tick_ev) |=> !tick_irq);
endmodule

bind tick_wdog_irq tick_wdog_irq_chk #(.AW(AW), .CW(CW), .EOI_ADDR(EOI_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .slow_ce(slow_ce), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .tick_ev(tick_ev), .cnt(cnt),
  .tick_irq(tick_irq), .wdog_irq(wdog_irq)
);

// File: tb/sim_tick_wdog_irq.sv
module sim_tick_wdog_irq;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int EOI = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slow_ce = 1'b0;
  logic test_bypass = 1'b0;
  logic bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic tick_irq, wdog_irq;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  tick_wdog_irq #(.AW(AW), .DW(DW), .EOI_ADDR(EOI)) u0 (
    .clk(clk), .rst_n(rst_n), .slow_ce(slow_ce), .test_bypass(test_bypass),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .tick_irq(tick_irq), .wdog_irq(wdog_irq)
  );

  // vector: {op[1:0], count[9:0], exp_tick, exp_wdog}
  // op 0: slow pulses, 1: acknowledge write, 2: write other address
  localparam logic [13:0] VEC [10] = '{
    {2'd0, 10'd511, 1'b0, 1'b0},
    {2'd0, 10'd1,   1'b1, 1'b0},
    {2'd2, 10'd0,   1'b1, 1'b0},
    {2'd1, 10'd0,   1'b0, 1'b0},
    {2'd0, 10'd512, 1'b1, 1'b0},
    {2'd0, 10'd512, 1'b1, 1'b1},
    {2'd0, 10'd512, 1'b1, 1'b1},
    {2'd1, 10'd0,   1'b0, 1'b0},
    {2'd0, 10'd511, 1'b0, 1'b0},
    {2'd0, 10'd1,   1'b1, 1'b0}
  };
  localparam string VTAG [10] = '{"R1", "R1", "R6", "R3", "R2",
                                  "R4", "R5", "R5", "R2", "R2"};

  task automatic check(input logic et, input logic ew, input string tag);
    n_chk++;
    if (tick_irq !== et || wdog_irq !== ew) begin
      n_fail++;
      $display("FAIL %s: tick=%b wdog=%b expected tick=%b wdog=%b",
               tag, tick_irq, wdog_irq, et, ew);
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) slow_ce = 1'b1;
      @(negedge clk) slow_ce = 1'b0;
    end
  endtask

  task automatic write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic ce);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; slow_ce = ce;
    @(negedge clk);
    bus_wr = 1'b0; slow_ce = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(1'b0, 1'b0, "R1 reset");
    rst_n = 1'b1;

    for (int k = 0; k < 10; k++) begin
      case (VEC[k][13:12])
        2'd0: pulses(int'(VEC[k][11:2]));
        2'd1: write(AW'(EOI), 32'h0000_0000, 1'b0);
        default: write(AW'(EOI + 4), 32'hFFFF_FFFF, 1'b0);
      endcase
      check(VEC[k][1], VEC[k][0], VTAG[k]);
    end

    // idle cycles without slow pulses: no change
    repeat (20) @(negedge clk);
    check(1'b1, 1'b0, "R2 idle");

    // R7: simultaneous tick and ack while pending
    pulses(511);
    check(1'b1, 1'b0, "R2 before edge");
    write(AW'(EOI), 32'h1234_5678, 1'b1);
    check(1'b1, 1'b1, "R7 pending");
    write(AW'(EOI), 32'hFFFF_FFFF, 1'b0);
    check(1'b0, 1'b0, "R6 data ignored");

    // R7: simultaneous tick and ack while not pending
    pulses(511);
    write(AW'(EOI), 32'h0, 1'b1);
    check(1'b1, 1'b0, "R7 not pending");
    write(AW'(EOI), 32'hA5A5_A5A5, 1'b0);
    check(1'b0, 1'b0, "R3 clear");

    // R8: bypass
    pulses(100);
    @(negedge clk) test_bypass = 1'b1;
    pulses(1);
    check(1'b1, 1'b0, "R8 bypass tick");
    pulses(1);
    check(1'b1, 1'b1, "R8 bypass wdog");
    write(AW'(EOI), 32'h0, 1'b0);
    @(negedge clk) test_bypass = 1'b0;
    pulses(511);
    check(1'b0, 1'b0, "R8 restart count");
    pulses(1);
    check(1'b1, 1'b0, "R8 restart tick");

    // reset mid-run
    pulses(512);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check(1'b0, 1'b0, "R1 reset mid-run");
    rst_n = 1'b1;
    pulses(511);
    check(1'b0, 1'b0, "R1 divider zeroed");
    pulses(1);
    check(1'b1, 1'b0, "R1 first tick");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule